// File: doc/BRIEF.md
# Programmable frame sync generator

This block produces a frame synchronization signal for a serial port. It advances on a one-cycle bit-clock enable strobe. When it is enabled and given a non-zero period, it divides the bit ticks into frames of 2*(period+1) bit times. At the first bit of each frame it issues a one-cycle start strobe, which the serializer and deserializer next to it use. The frame sync output can take one of six shapes. It can stay silent. It can give a low-going or a high-going pulse of 1 to 16 bit times at the head of every frame. It can hold a low or a high level for as long as frames are running. It can flip its level at every frame start.

A separate path watches an incoming frame sync line. The line first passes through a synchronizer. The path then looks for the edge chosen by an edge select input, and a detected edge sets a sticky flag. Software clears the flag with a one-cycle read-clear strobe. If a new edge arrives in the same cycle as the clear, the edge wins and the flag stays set.

The sequencer is a three-state machine:
- ST_IDLE: no frame is running.
- ST_SYNC: the sync portion at the head of a frame.
- ST_REST: the remainder of the frame.

Its transitions are:
- LAUNCH: ST_IDLE to ST_SYNC, on a tick with a non-zero period.
- HOLD_SYNC: ST_SYNC to ST_SYNC, on a tick while the length count runs.
- END_SYNC: ST_SYNC to ST_REST, when the length count is reached.
- ADVANCE: ST_REST to ST_REST, on a tick inside the frame.
- RESTART: ST_SYNC or ST_REST to ST_SYNC, on a tick at the last frame position.
- PARK: any state to ST_IDLE, when the enable is low or, on a tick, the period is zero.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset the output frame_sync is 0 when wave_sel is 0, start_stb is 0, and sync_flag is 0.
- R2: While enable is 1 and period_sel is P with P > 0, the first bit_en tick starts a frame, and a new frame starts every 2*(P+1) ticks. start_stb is 1 for the single clock that follows the clock edge which samples the starting tick, and is 0 at all other times.
- R3: When period_sel is 0 at a tick, no frame is started and start_stb stays 0. When enable is 0, the block returns to idle on the next clock and start_stb stays 0.
- R4: The sync portion covers frame positions 0 to len_sel, which is len_sel+1 bit times (1 to 16). If this span reaches the end of the frame, the sync portion continues without a gap into the next frame.
- R5: wave_sel 2 (positive pulse) drives frame_sync high during the sync portion and low otherwise, including while idle. wave_sel 1 (negative pulse) is the inverse of this and is high while idle.
- R6: wave_sel 3 (level low) drives 0 while frames run and 1 while idle. wave_sel 4 (level high) drives 1 while frames run and 0 while idle. wave_sel 0 and the unused codes 6 and 7 drive 0.
- R7: wave_sel 5 (toggle) inverts frame_sync at every frame start. Its level is 0 after reset.
- R8: All frame outputs change on the clock edge that samples the bit_en tick.
- R9: With edge_sel 0 a rising edge on fs_in sets sync_flag, and with edge_sel 1 a falling edge sets it. The opposite edge has no effect. The flag becomes 1 on the third clock edge after fs_in changes.
- R10: sync_flag stays 1 until flag_clr is 1 for a clock. An edge detected in the same cycle as flag_clr keeps the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle bit tick |
| enable | input | 1 | Frame generation enable |
| wave_sel | input | 3 | Output shape: 0 none, 1 neg pulse, 2 pos pulse, 3 low, 4 high, 5 toggle |
| len_sel | input | 4 | Sync length minus one, in bit times |
| period_sel | input | PERIOD_W | Half frame length minus one; 0 stops generation |
| edge_sel | input | 1 | 0 rising, 1 falling edge detection |
| fs_in | input | 1 | Incoming frame sync line |
| flag_clr | input | 1 | Read-clear strobe for sync_flag |
| frame_sync | output | 1 | Frame sync output |
| start_stb | output | 1 | Frame start strobe |
| sync_flag | output | 1 | Sticky edge-detected flag |

## Verification
Every frame output changes on the clock edge that samples a tick. The bench therefore raises bit_en for one clock and checks frame_sync and start_stb at the following falling edge. It then checks once more a clock later, to confirm that the strobe has dropped and the level has held. For each tick index k the expected level is computed from the frame position k mod 2*(P+1) and from the frame count. The flag path passes through two synchronizer stages and one flag register, so the bench checks sync_flag as 0 after two clock edges and as 1 after three. The clear and the clear-collision cases are timed to land on that third edge.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_REST = 2'd2
    } fsg_state_t;

    typedef enum logic [2:0] {
        WAVE_NONE   = 3'd0,
        WAVE_NEG    = 3'd1,
        WAVE_POS    = 3'd2,
        WAVE_LOW    = 3'd3,
        WAVE_HIGH   = 3'd4,
        WAVE_TOGGLE = 3'd5
    } fsg_wave_t;

    localparam int LEN_W = 4;

endpackage

// File: rtl/fsg_sequencer.sv
module fsg_sequencer
    import fsg_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                enable,
    input  logic [LEN_W-1:0]    len_sel,
    input  logic [PERIOD_W-1:0] period_sel,
    output fsg_state_t          state,
    output logic                frame_begin,
    output logic                start_stb
);

    localparam int POS_W = PERIOD_W + 1;

    fsg_state_t         state_q, state_d;
    logic [POS_W-1:0]   pos_q, pos_d;
    logic [LEN_W-1:0]   len_q, len_d;
    logic               start_q;
    logic               begin_c;
    logic [POS_W-1:0]   last_pos;
    logic               period_zero;

    assign last_pos    = {period_sel, 1'b1};
    assign period_zero = (period_sel == '0);

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        len_d   = len_q;
        begin_c = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
        end else if (bit_en) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!period_zero) begin
                        state_d = ST_SYNC;
                        pos_d   = '0;
                        len_d   = '0;
                        begin_c = 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (period_zero) begin
                        state_d = ST_IDLE;
                    end else if (pos_q >= last_pos) begin
                        state_d = ST_SYNC;
                        pos_d   = '0;
                        len_d   = '0;
                        begin_c = 1'b1;
                    end else begin
                        pos_d = pos_q + 1'b1;
                        if (len_q >= len_sel) begin
                            state_d = ST_REST;
                        end else begin
                            len_d = len_q + 1'b1;
                        end
                    end
                end
                ST_REST: begin
                    if (period_zero) begin
                        state_d = ST_IDLE;
                    end else if (pos_q >= last_pos) begin
                        state_d = ST_SYNC;
                        pos_d   = '0;
                        len_d   = '0;
                        begin_c = 1'b1;
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            len_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            len_q   <= len_d;
            start_q <= begin_c;
        end
    end

    always_comb begin
        state       = state_q;
        frame_begin = begin_c;
        start_stb   = start_q;
    end

endmodule

// File: rtl/fsg_shaper.sv
module fsg_shaper
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fsg_state_t state,
    input  logic       frame_begin,
    input  logic [2:0] wave_sel,
    output logic       frame_sync
);

    logic toggle_q;
    logic running;
    logic in_sync;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
        end else if (frame_begin) begin
            toggle_q <= ~toggle_q;
        end
    end

    assign running = (state != ST_IDLE);
    assign in_sync = (state == ST_SYNC);

    always_comb begin
        unique case (wave_sel)
            WAVE_NONE:   frame_sync = 1'b0;
            WAVE_NEG:    frame_sync = ~in_sync;
            WAVE_POS:    frame_sync = in_sync;
            WAVE_LOW:    frame_sync = ~running;
            WAVE_HIGH:   frame_sync = running;
            WAVE_TOGGLE: frame_sync = toggle_q;
            default:     frame_sync = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsg_edge_detect.sv
module fsg_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_in,
    input  logic edge_sel,
    input  logic flag_clr,
    output logic sync_flag
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   flag_q;
    logic                   seen;
    logic                   cur;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= fs_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign cur  = chain_q[SYNC_STAGES-1];
    assign seen = edge_sel ? (prev_q & ~cur) : (~prev_q & cur);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= cur;
            flag_q <= seen | (flag_q & ~flag_clr);
        end
    end

    assign sync_flag = flag_q;

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int PERIOD_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                enable,
    input  logic [2:0]          wave_sel,
    input  logic [LEN_W-1:0]    len_sel,
    input  logic [PERIOD_W-1:0] period_sel,
    input  logic                edge_sel,
    input  logic                fs_in,
    input  logic                flag_clr,
    output logic                frame_sync,
    output logic                start_stb,
    output logic                sync_flag
);

    fsg_state_t seq_state;
    logic       seq_begin;

    fsg_sequencer #(.PERIOD_W(PERIOD_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .enable      (enable),
        .len_sel     (len_sel),
        .period_sel  (period_sel),
        .state       (seq_state),
        .frame_begin (seq_begin),
        .start_stb   (start_stb)
    );

    fsg_shaper u_shape (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (seq_state),
        .frame_begin (seq_begin),
        .wave_sel    (wave_sel),
        .frame_sync  (frame_sync)
    );

    fsg_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_in     (fs_in),
        .edge_sel  (edge_sel),
        .flag_clr  (flag_clr),
        .sync_flag (sync_flag)
    );

endmodule

// File: rtl/frame_sync_gen_chk.sv
module frame_sync_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       enable,
    input logic [2:0] wave_sel,
    input logic       flag_clr,
    input logic       frame_sync,
    input logic       start_stb,
    input logic       sync_flag
);

    assert_single_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !start_stb);

    assert_start_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |-> $past(bit_en));

    assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !start_stb);

    assert_pos_pulse_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_stb && wave_sel == 3'd2) |-> frame_sync);

    assert_high_level_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_stb && wave_sel == 3'd4) |-> frame_sync);

    assert_toggle_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_stb && wave_sel == 3'd5 && $past(wave_sel) == 3'd5)
            |-> (frame_sync != $past(frame_sync)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_flag && !flag_clr) |=> sync_flag);

endmodule

bind frame_sync_gen frame_sync_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .enable     (enable),
    .wave_sel   (wave_sel),
    .flag_clr   (flag_clr),
    .frame_sync (frame_sync),
    .start_stb  (start_stb),
    .sync_flag  (sync_flag)
);

// File: tb/tb_frame_sync_gen.sv
`timescale 1ns/1ps
module tb_frame_sync_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] wave_sel = 3'd0;
    logic [3:0] len_sel = 4'd0;
    logic [7:0] period_sel = 8'd0;
    logic       edge_sel = 1'b0;
    logic       fs_in = 1'b0;
    logic       flag_clr = 1'b0;
    logic       frame_sync;
    logic       start_stb;
    logic       sync_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    frame_sync_gen dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .enable(enable),
        .wave_sel(wave_sel), .len_sel(len_sel), .period_sel(period_sel),
        .edge_sel(edge_sel), .fs_in(fs_in), .flag_clr(flag_clr),
        .frame_sync(frame_sync), .start_stb(start_stb), .sync_flag(sync_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; enable = 1'b0; bit_en = 1'b0; flag_clr = 1'b0; fs_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick();
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    function automatic int idle_level(input int w);
        return (w == 1 || w == 3) ? 1 : 0;
    endfunction

    function automatic int run_level(input int w, input int k, input int per, input int len);
        int f, p, act;
        f = 2 * (per + 1);
        p = k % f;
        act = (p <= len) ? 1 : 0;
        case (w)
            1: return 1 - act;
            2: return act;
            3: return 0;
            4: return 1;
            5: return ((k / f) + 1) % 2;
            default: return 0;
        endcase
    endfunction

    initial begin
        int lens[4] = '{0, 1, 3, 15};
        do_reset();
        // R1 reset state
        check("R1", "frame_sync", frame_sync, 0);
        check("R1", "start_stb", start_stb, 0);
        check("R1", "sync_flag", sync_flag, 0);

        for (int w = 0; w < 8; w++) begin
            for (int li = 0; li < 4; li++) begin
                for (int per = 1; per <= 3; per++) begin
                    int f;
                    f = 2 * (per + 1);
                    do_reset();
                    wave_sel = w[2:0]; len_sel = lens[li][3:0]; period_sel = per[7:0];
                    enable = 1'b1;
                    @(negedge clk);
                    check("R6", "idle level", frame_sync, idle_level(w));
                    for (int k = 0; k < 2 * f + 3; k++) begin
                        int e;
                        tick();
                        e = run_level(w, k, per, lens[li]);
                        // R8: outputs take effect at the tick edge
                        check((w == 5) ? "R7" : (w < 3 || w > 5) ? "R5" : "R6",
                              "level after tick", frame_sync, e);
                        check("R2", "start after tick", start_stb, ((k % f) == 0) ? 1 : 0);
                        if (lens[li] >= f - 1 && w == 2)
                            check("R4", "continuous sync", frame_sync, 1);
                        @(negedge clk);
                        check("R2", "start drops", start_stb, 0);
                        check("R8", "level holds", frame_sync, e);
                    end
                    // R3 disable returns to idle next clock
                    enable = 1'b0;
                    @(negedge clk);
                    check("R3", "idle after disable", frame_sync,
                          (w == 5) ? run_level(w, 2 * f + 2, per, lens[li]) : idle_level(w));
                    tick();
                    check("R3", "no start disabled", start_stb, 0);
                end
            end
        end

        // R3 period zero: no frames
        for (int w = 1; w < 6; w++) begin
            do_reset();
            wave_sel = w[2:0]; period_sel = 8'd0; len_sel = 4'd2; enable = 1'b1;
            for (int k = 0; k < 6; k++) begin
                tick();
                check("R3", "period zero start", start_stb, 0);
                check("R3", "period zero level", frame_sync, idle_level(w));
            end
        end

        // R9 edge detection, rising select
        do_reset();
        edge_sel = 1'b0;
        fs_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", "rise flag after 2", sync_flag, 0);
        @(negedge clk);
        check("R9", "rise flag after 3", sync_flag, 1);
        // R10 sticky
        repeat (4) @(negedge clk);
        check("R10", "flag sticky", sync_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R10", "flag cleared", sync_flag, 0);
        // R9 falling edge ignored with rising select
        fs_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R9", "fall ignored", sync_flag, 0);

        // R9 falling select
        edge_sel = 1'b1;
        fs_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R9", "rise ignored falling sel", sync_flag, 0);
        fs_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "fall flag", sync_flag, 1);

        // R10 edge collides with clear: edge wins
        edge_sel = 1'b0;
        repeat (3) @(negedge clk);
        fs_in = 1'b1;
        repeat (2) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R10", "edge wins over clear", sync_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R10", "clear without edge", sync_flag, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule